// File: doc/BRIEF.md
# Suspend and Wakeup Power Controller

This block moves a small processor-based chip into a low-power suspend state and brings it back out. Firmware requests suspend by setting one control bit. The CPU is then held, and after a short entry window the block turns off the oscillator enable and the PLL enable. While the chip is suspended, three sources can wake it: activity on the host bus, a primary wake pin, and a secondary wake pin. The secondary pin can instead be used as a general-purpose input.

A wake event runs a fixed sequence. The oscillator enable comes back first and stays on alone for a programmed number of cycles. Next the PLL enable comes on. The block then waits for a programmed settle count and for the PLL-ready input. Only after that does it raise a sticky wakeup interrupt, and at the same moment it clears the suspend request bit. Every wake input passes through a two-flop synchronizer and can be qualified by level or by edge. The wake inputs can be selected for each pin, and the two pins default to active low. A wake that arrives during the entry window cancels the entry.

The block also holds its system reset output low for a selectable time after its own reset is released. A long count is used for a crystal clock source and a short count for an external clock. Wake behaviour does not depend on whether a host is attached: bus activity is just one more wake input.

Top module: `pwr_suspend_ctrl`

## Requirements
- R1: After reset, osc_en=1, pll_en=1, cpu_halt=0 and wake_irq=0. Register 1 reads 4'b0100 and register 0 reads 0.
- R2: A write with reg_addr=0 and reg_wdata[0]=1 while running is accepted on one clock edge. cpu_halt is high from the following edge. osc_en stays high for exactly ENTER_CYC cycles with cpu_halt high, and then osc_en and pll_en are both low.
- R3: On wake, osc_en rises while pll_en stays low for exactly OSC_CYC cycles. pll_en then rises. The PLL stage lasts PLL_CYC cycles, or longer while pll_ready is low, and wake_irq cannot rise before both conditions are met.
- R4: The edge that sets wake_irq also drops cpu_halt and clears the suspend request bit (register 0 bit 0 reads 0).
- R5: wake_irq stays set until a write to register 2 with bit 0 set. Writing 0 there has no effect. A clear in the same cycle as a new interrupt leaves wake_irq set.
- R6: While suspended, each of bus_activity (active high), wu1_pin and wu2_pin starts the wake sequence.
- R7: Register 1 bit 0 sets the wu1_pin polarity and bit 1 sets the wu2_pin polarity (0 = active low, 1 = active high). A pin held at its inactive level does not wake.
- R8: Register 1 bit 2 = 0 makes wu2_pin a general-purpose input that never wakes. Register 3 bits 2:0 always read the synchronized levels of wu2_pin, wu1_pin and bus_activity.
- R9: Register 1 bit 3 = 1 selects edge qualification. An input already active when suspend is entered does not wake, and a new transition to the active level does. With bit 3 = 0, the active level alone wakes.
- R10: A wake event during the entry window cancels the entry: osc_en never falls, and the wake sequence and interrupt follow.
- R11: After rst_n is released, sys_rst_n rises on the (N+2)th rising clock edge. N = XTAL_RST_CYC when clk_sel_xtal=1 and EXT_RST_CYC otherwise.
- R12: Wake inputs have no effect while running: cpu_halt and wake_irq stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel_xtal | input | 1 | 1 = crystal clock source (long reset stretch) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data (combinational) |
| bus_activity | input | 1 | Host bus activity indication, active high |
| wu1_pin | input | 1 | Primary wake pin |
| wu2_pin | input | 1 | Secondary wake pin or general-purpose input |
| pll_ready | input | 1 | PLL lock indication |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_halt | output | 1 | CPU held in power-down |
| wake_irq | output | 1 | Sticky wakeup interrupt flag |
| sys_rst_n | output | 1 | Stretched system reset, active low |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the firmware interrupt clear and the interrupt set that ends the PLL stage. To provoke it, the bench keeps pll_ready low past the settle count. It then raises pll_ready in the same cycle as a clear write, and expects wake_irq to be set afterwards.

The second pair is a wake event and the end of the entry window. To provoke it, the bench asserts bus activity right after the suspend write. It then checks that osc_en never drops and that the interrupt still arrives.

// File: rtl/pwr_suspend_pkg.sv
package pwr_suspend_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTER,
    ST_SLEEP,
    ST_OSC,
    ST_PLL
  } pwr_state_t;

  // Register 1 layout, MSB first: bit3 edge, bit2 wu2 wake, bit1 wu2 pol, bit0 wu1 pol
  typedef struct packed {
    logic edge_mode;
    logic wu2_wake;
    logic wu2_pol;
    logic wu1_pol;
  } wake_cfg_t;

  localparam logic [3:0] CFG_RESET = 4'b0100;
  localparam int NUM_SRC = 3;   // 0 bus, 1 wu1, 2 wu2

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_CFG   = 2'd1;
  localparam logic [1:0] ADDR_IRQ   = 2'd2;
  localparam logic [1:0] ADDR_LEVEL = 2'd3;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic qualify(input logic act, input logic prev_act,
                                   input logic edge_mode);
    return edge_mode ? (act & ~prev_act) : act;
  endfunction

  function automatic int stretch_len(input logic xtal, input int xtal_cyc,
                                     input int ext_cyc);
    return xtal ? xtal_cyc : ext_cyc;
  endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic invert_i,
  input  logic edge_mode_i,
  output logic level_o,
  output logic qual_o
);
  import pwr_suspend_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   active;
  logic                   prev_active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q        <= '0;
      prev_active_q <= 1'b0;
    end else begin
      sync_q        <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_active_q <= active;
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];
  assign active  = level_o ^ invert_i;
  assign qual_o  = qualify(active, prev_active_q, edge_mode_i);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm #(
  parameter int ENTER_CYC = 4,
  parameter int OSC_CYC   = 16,
  parameter int PLL_CYC   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req_i,
  input  logic wake_evt_i,
  input  logic pll_ready_i,
  output logic irq_set_o,
  output logic osc_en_o,
  output logic pll_en_o,
  output logic cpu_halt_o
);
  import pwr_suspend_pkg::*;

  localparam int MAXC = max3(ENTER_CYC, OSC_CYC, PLL_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  pwr_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (pd_req_i) begin
            state_q <= ST_ENTER;
            cnt_q   <= CW'(ENTER_CYC - 1);
          end
        end
        ST_ENTER: begin
          if (wake_evt_i) begin
            state_q <= ST_OSC;
            cnt_q   <= CW'(OSC_CYC - 1);
          end else if (cnt_zero) begin
            state_q <= ST_SLEEP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_SLEEP: begin
          if (wake_evt_i) begin
            state_q <= ST_OSC;
            cnt_q   <= CW'(OSC_CYC - 1);
          end
        end
        ST_OSC: begin
          if (cnt_zero) begin
            state_q <= ST_PLL;
            cnt_q   <= CW'(PLL_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PLL: begin
          if (!cnt_zero)         cnt_q   <= cnt_q - 1'b1;
          else if (pll_ready_i)  state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign irq_set_o  = (state_q == ST_PLL) && cnt_zero && pll_ready_i;
  assign osc_en_o   = (state_q != ST_SLEEP);
  assign pll_en_o   = (state_q == ST_RUN) || (state_q == ST_ENTER) ||
                      (state_q == ST_PLL);
  assign cpu_halt_o = (state_q != ST_RUN);

endmodule

// File: rtl/pwr_rst_stretch.sv
module pwr_rst_stretch #(
  parameter int XTAL_CYC = 250000,
  parameter int EXT_CYC  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_sel_i,
  output logic rst_out_n
);
  import pwr_suspend_pkg::*;

  localparam int MAXC = (XTAL_CYC > EXT_CYC) ? XTAL_CYC : EXT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          loaded_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (!loaded_q) begin
        cnt_q    <= CW'(stretch_len(xtal_sel_i, XTAL_CYC, EXT_CYC));
        loaded_q <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      done_q <= loaded_q && (cnt_q == '0);
    end
  end

  assign rst_out_n = done_q;

endmodule

// File: rtl/pwr_suspend_ctrl.sv
module pwr_suspend_ctrl #(
  parameter int ENTER_CYC    = 4,
  parameter int OSC_CYC      = 16,
  parameter int PLL_CYC      = 32,
  parameter int XTAL_RST_CYC = 250000,
  parameter int EXT_RST_CYC  = 10000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_sel_xtal,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [3:0] reg_wdata,
  output logic [3:0] reg_rdata,
  input  logic       bus_activity,
  input  logic       wu1_pin,
  input  logic       wu2_pin,
  input  logic       pll_ready,
  output logic       osc_en,
  output logic       pll_en,
  output logic       cpu_halt,
  output logic       wake_irq,
  output logic       sys_rst_n
);
  import pwr_suspend_pkg::*;

  wake_cfg_t          cfg_q;
  logic               pd_bit;
  logic               irq_q;
  logic               irq_set;
  logic               irq_clr;
  logic               wake_evt;
  logic [NUM_SRC-1:0] src_pin;
  logic [NUM_SRC-1:0] src_inv;
  logic [NUM_SRC-1:0] src_mask;
  logic [NUM_SRC-1:0] src_level;
  logic [NUM_SRC-1:0] src_qual;

  assign src_pin  = {wu2_pin, wu1_pin, bus_activity};
  assign src_inv  = {~cfg_q.wu2_pol, ~cfg_q.wu1_pol, 1'b0};
  assign src_mask = {cfg_q.wu2_wake, 1'b1, 1'b1};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    pwr_wake_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (src_pin[i]),
      .invert_i    (src_inv[i]),
      .edge_mode_i (cfg_q.edge_mode),
      .level_o     (src_level[i]),
      .qual_o      (src_qual[i])
    );
  end

  assign wake_evt = |(src_qual & src_mask);
  assign irq_clr  = reg_wr && (reg_addr == ADDR_IRQ) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= wake_cfg_t'(CFG_RESET);
      pd_bit <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (reg_wr && (reg_addr == ADDR_CFG)) cfg_q <= wake_cfg_t'(reg_wdata);
      if (irq_set)
        pd_bit <= 1'b0;
      else if (reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[0] && !cpu_halt)
        pd_bit <= 1'b1;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  pwr_seq_fsm #(
    .ENTER_CYC (ENTER_CYC),
    .OSC_CYC   (OSC_CYC),
    .PLL_CYC   (PLL_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req_i    (pd_bit),
    .wake_evt_i  (wake_evt),
    .pll_ready_i (pll_ready),
    .irq_set_o   (irq_set),
    .osc_en_o    (osc_en),
    .pll_en_o    (pll_en),
    .cpu_halt_o  (cpu_halt)
  );

  pwr_rst_stretch #(
    .XTAL_CYC (XTAL_RST_CYC),
    .EXT_CYC  (EXT_RST_CYC)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .xtal_sel_i (clk_sel_xtal),
    .rst_out_n  (sys_rst_n)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = {3'b000, pd_bit};
      ADDR_CFG:  reg_rdata = cfg_q;
      ADDR_IRQ:  reg_rdata = {3'b000, irq_q};
      default:   reg_rdata = {1'b0, src_level};
    endcase
  end

  assign wake_irq = irq_q;

endmodule

// File: rtl/pwr_suspend_ctrl_chk.sv
module pwr_suspend_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic pll_en,
  input logic cpu_halt,
  input logic wake_irq,
  input logic pll_ready,
  input logic irq_set,
  input logic irq_clr,
  input logic pd_bit
);

  // R2
  sleep_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && !osc_en) |-> !pll_en);

  // R3
  pll_after_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> ($past(osc_en) && osc_en));

  // R3
  irq_waits_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (pll_ready && pll_en && osc_en && cpu_halt));

  // R4
  wake_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> (wake_irq && !pd_bit && !cpu_halt));

  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !irq_clr) |=> wake_irq);

  // R12
  run_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_halt && !pd_bit) |=> !cpu_halt);

endmodule

bind pwr_suspend_ctrl pwr_suspend_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .osc_en    (osc_en),
  .pll_en    (pll_en),
  .cpu_halt  (cpu_halt),
  .wake_irq  (wake_irq),
  .pll_ready (pll_ready),
  .irq_set   (irq_set),
  .irq_clr   (irq_clr),
  .pd_bit    (pd_bit)
);

// File: tb/pwr_suspend_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_suspend_ctrl_tb;

  localparam int ENTER_CYC = 6;
  localparam int OSC_CYC   = 5;
  localparam int PLL_CYC   = 9;
  localparam int XTAL_RST  = 40;
  localparam int EXT_RST   = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_sel_xtal = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [3:0] reg_wdata = 4'd0;
  logic [3:0] reg_rdata;
  logic       bus_activity = 1'b0;
  logic       wu1_pin = 1'b1;
  logic       wu2_pin = 1'b1;
  logic       pll_ready = 1'b1;
  logic       osc_en, pll_en, cpu_halt, wake_irq, sys_rst_n;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pwr_suspend_ctrl #(
    .ENTER_CYC(ENTER_CYC), .OSC_CYC(OSC_CYC), .PLL_CYC(PLL_CYC),
    .XTAL_RST_CYC(XTAL_RST), .EXT_RST_CYC(EXT_RST)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel_xtal(clk_sel_xtal),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_activity(bus_activity),
    .wu1_pin(wu1_pin), .wu2_pin(wu2_pin), .pll_ready(pll_ready),
    .osc_en(osc_en), .pll_en(pll_en), .cpu_halt(cpu_halt),
    .wake_irq(wake_irq), .sys_rst_n(sys_rst_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [3:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic xtal, input string req, input int exp_low);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    clk_sel_xtal = xtal;
    idle(3);
    rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sys_rst_n) break;
      n++;
    end
    check(req, n, exp_low);
  endtask

  task automatic enter_sleep(input string req);
    reg_write(2'd0, 4'h1);
    idle(ENTER_CYC + 2);
    check(req, {osc_en, pll_en}, 0);
  endtask

  // waits for osc restart, then measures the oscillator-only and PLL stages
  task automatic run_wake(input string req);
    int n_osc, n_pll;
    for (int i = 0; i < 12; i++) begin
      if (osc_en) break;
      @(negedge clk);
    end
    check({req, " osc restarted"}, osc_en, 1);
    n_osc = 0;
    for (int i = 0; i < 40; i++) begin
      if (!(osc_en && !pll_en)) break;
      n_osc++;
      @(negedge clk);
    end
    n_pll = 0;
    for (int i = 0; i < 60; i++) begin
      if (!(pll_en && cpu_halt)) break;
      n_pll++;
      @(negedge clk);
    end
    check({req, " R3 osc-only cycles"}, n_osc, OSC_CYC);
    check({req, " R3 pll cycles"}, n_pll, PLL_CYC);
    check({req, " R4 irq set"}, wake_irq, 1);
    check({req, " R4 cpu released"}, cpu_halt, 0);
  endtask

  task automatic clear_irq();
    reg_write(2'd2, 4'h1);
  endtask

  task automatic t_reset_state();
    logic [3:0] d;
    check("R1 osc_en", osc_en, 1);
    check("R1 pll_en", pll_en, 1);
    check("R1 cpu_halt", cpu_halt, 0);
    check("R1 wake_irq", wake_irq, 0);
    reg_read(2'd1, d); check("R1 cfg reset", d, 4);
    reg_read(2'd0, d); check("R1 ctrl reset", d, 0);
  endtask

  task automatic t_run_ignore();
    bus_activity = 1'b1; wu1_pin = 1'b0; wu2_pin = 1'b0;
    idle(10);
    check("R12 halt in run", cpu_halt, 0);
    check("R12 irq in run", wake_irq, 0);
    bus_activity = 1'b0; wu1_pin = 1'b1; wu2_pin = 1'b1;
    idle(4);
  endtask

  task automatic t_entry_bus_wake();
    logic [3:0] d;
    int n;
    reg_write(2'd0, 4'h1);
    check("R2 halt not yet", cpu_halt, 0);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!(cpu_halt && osc_en)) break;
      n++;
    end
    check("R2 entry cycles", n, ENTER_CYC);
    check("R2 gated", {osc_en, pll_en}, 0);
    idle(10);
    check("R2 stays asleep", osc_en, 0);
    bus_activity = 1'b1;
    run_wake("R6 bus");
    reg_read(2'd0, d); check("R4 pd bit cleared", d, 0);
    bus_activity = 1'b0;
    reg_write(2'd2, 4'h0);
    idle(2);
    check("R5 write 0 keeps irq", wake_irq, 1);
    clear_irq();
    check("R5 cleared", wake_irq, 0);
  endtask

  task automatic t_pin_wakes();
    enter_sleep("R6 wu1 sleep");
    wu1_pin = 1'b0;
    run_wake("R6 wu1");
    wu1_pin = 1'b1; clear_irq(); idle(3);
    enter_sleep("R6 wu2 sleep");
    wu2_pin = 1'b0;
    run_wake("R6 wu2");
    wu2_pin = 1'b1; clear_irq(); idle(3);
  endtask

  task automatic t_polarity();
    wu1_pin = 1'b0;
    reg_write(2'd1, 4'h5);
    enter_sleep("R7 wu1 high pol sleep");
    idle(10);
    check("R7 inactive-low wu1 no wake", osc_en, 0);
    wu1_pin = 1'b1;
    run_wake("R7 wu1 active high");
    reg_write(2'd1, 4'h4); clear_irq();
    wu2_pin = 1'b0;
    reg_write(2'd1, 4'h6);
    enter_sleep("R7 wu2 high pol sleep");
    idle(10);
    check("R7 inactive-low wu2 no wake", osc_en, 0);
    wu2_pin = 1'b1;
    run_wake("R7 wu2 active high");
    reg_write(2'd1, 4'h4); clear_irq(); idle(3);
  endtask

  task automatic t_gpio();
    logic [3:0] d;
    reg_write(2'd1, 4'h0);
    enter_sleep("R8 sleep");
    wu2_pin = 1'b0;
    idle(10);
    check("R8 gpio no wake", osc_en, 0);
    reg_read(2'd3, d); check("R8 levels wu2 low", d, 4'b0010);
    wu2_pin = 1'b1;
    idle(3);
    reg_read(2'd3, d); check("R8 levels wu2 high", d, 4'b0110);
    bus_activity = 1'b1;
    run_wake("R8 bus after gpio");
    bus_activity = 1'b0;
    reg_write(2'd1, 4'h4); clear_irq(); idle(3);
  endtask

  task automatic t_edge();
    reg_write(2'd1, 4'hC);
    bus_activity = 1'b1;
    idle(4);
    enter_sleep("R9 held input no wake on entry");
    idle(10);
    check("R9 held input stays asleep", osc_en, 0);
    bus_activity = 1'b0;
    idle(4);
    bus_activity = 1'b1;
    run_wake("R9 new edge");
    bus_activity = 1'b0;
    reg_write(2'd1, 4'h4); clear_irq(); idle(3);
  endtask

  task automatic t_abort();
    int dropped;
    reg_write(2'd0, 4'h1);
    bus_activity = 1'b1;
    dropped = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!osc_en) dropped = 1;
      if (wake_irq) break;
    end
    check("R10 osc never dropped", dropped, 0);
    check("R10 irq after abort", wake_irq, 1);
    check("R10 cpu released", cpu_halt, 0);
    bus_activity = 1'b0;
    clear_irq(); idle(3);
  endtask

  task automatic t_collision();
    pll_ready = 1'b0;
    enter_sleep("R5 collision sleep");
    bus_activity = 1'b1;
    idle(OSC_CYC + PLL_CYC + 10);
    check("R3 no irq without pll_ready", wake_irq, 0);
    check("R3 still halted", cpu_halt, 1);
    @(negedge clk);
    pll_ready = 1'b1;
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 4'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R5 set wins over clear", wake_irq, 1);
    check("R4 released after ready", cpu_halt, 0);
    bus_activity = 1'b0;
    clear_irq();
    check("R5 cleared after collision", wake_irq, 0);
  endtask

  initial begin
    do_reset(1'b1, "R11 crystal stretch", XTAL_RST + 1);
    t_reset_state();
    t_run_ignore();
    t_entry_bus_wake();
    t_pin_wakes();
    t_polarity();
    t_gpio();
    t_edge();
    t_abort();
    t_collision();
    do_reset(1'b0, "R11 external clock stretch", EXT_RST + 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule